// File: doc/BRIEF.md
# USB Bus-State Interrupt Controller

This block watches the two USB data lines and turns their states into three bus events: a bus reset (both lines held low for long enough), entry into suspend (the bus left idle for a long interval), and resume (a J-to-K transition while suspended). The lines are synchronised into the system clock domain first. Line-state timing is counted in system clocks, so the thresholds are parameters that are set from the clock frequency.

Each event sets a sticky flag. A live suspend indicator sits beside the sticky flags. Two DMA-complete pulses and a level-sensitive protocol-handler interrupt line also feed the status word. A per-source enable word selects which flags drive the single interrupt output. Software reaches the enable, status and reset-status words through a plain single-cycle register port: a write is taken on any clock edge where the write strobe is high, and read data is combinational from the address. The port has no back-pressure, because every access completes in one cycle.

Top module: `usb_bus_irq_ctrl`

## Requirements
- R1: After reset, the enable word, the status word and the reset-status word all read 0x0000, and `irq_o` is low.
- R2: Line encoding is {dp,dm}. J is 10, K is 01, SE0 is 00 and SE1 is 11. After a two-stage synchroniser, SE0 seen for SE0_CYCLES consecutive samples sets bit 4 of the reset-status word (address 2). A shorter SE0 run does not set it.
- R3: While not suspended, J seen for IDLE_CYCLES consecutive synchronised samples sets the live bit 8 and the sticky bit 1 of the status word (address 1). Any K, SE0 or SE1 sample restarts the count.
- R4: While suspended, a J sample followed directly by a K sample clears status bit 8 and sets sticky bit 0.
- R5: A bus reset while suspended clears status bit 8 and does not set bit 0.
- R6: Status bit 6 follows the `ph_irq_i` input. Bits 10 and 9 are set on the clock edge that samples `tx_dma_done_i` and `rx_dma_done_i` high, respectively.
- R7: The enable word (address 0) keeps bits 10, 9, 8, 6, 1 and 0. Its other bits read as zero. Address 3 reads zero.
- R8: `irq_o` is the OR of these pairs: status 10, 9, 6, 1 and 0 each with the same enable bit, and reset-status bit 4 with enable bit 8. An event whose enable bit is clear still sets its flag.
- R9: Writing 1 clears status bits 10, 9, 1 and 0 and reset-status bit 4. Writes to status bits 8 and 6 have no effect. An event arriving in the same cycle as its clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| usb_dp_i | input | 1 | USB D+ line, asynchronous |
| usb_dm_i | input | 1 | USB D- line, asynchronous |
| ph_irq_i | input | 1 | Protocol-handler interrupt level |
| tx_dma_done_i | input | 1 | Transmit DMA complete pulse |
| rx_dma_done_i | input | 1 | Receive DMA complete pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 enable, 1 status, 2 reset status |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with SE0_CYCLES = 8 and IDLE_CYCLES = 40, in place of the thousands of clocks that real time intervals need. With these values, both threshold edges (one sample short and exactly at the limit) can be reached in a few dozen cycles. A full suspend, resume and reset sequence, including a bus reset that ends a suspend, fits in a short table walk. The enable pairing, the write-one-to-clear rules and the case where a set and a clear arrive together are then covered by directed accesses.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

  // {dp,dm} line encoding
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_K   = 2'b01,
    LS_J   = 2'b10,
    LS_SE1 = 2'b11
  } line_state_e;

  // register select
  localparam logic [1:0] ADDR_ENABLE = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam logic [1:0] ADDR_RSTSTS = 2'd2;

  // bit positions shared by enable and status words
  localparam int unsigned B_TXDMA = 10;
  localparam int unsigned B_RXDMA = 9;
  localparam int unsigned B_BUSRST_EN = 8;
  localparam int unsigned B_LIVE_SUSP = 8;
  localparam int unsigned B_PHLINE = 6;
  localparam int unsigned B_SUSP = 1;
  localparam int unsigned B_RSM = 0;
  localparam int unsigned B_RSTFLAG = 4;

  localparam logic [15:0] ENABLE_IMPL = 16'h0743;

  typedef struct packed {
    logic bus_rst;
    logic susp;
    logic rsm;
  } bus_evt_t;

  typedef struct packed {
    logic tx;
    logic rx;
    logic bus_rst;
    logic susp;
    logic rsm;
  } flag_t;

endpackage

// File: rtl/usb_line_sync.sv
module usb_line_sync
  import usb_irq_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        dp_i,
  input  logic        dm_i,
  output line_state_e state_o
);

  logic [1:0] sr [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr[g] <= LS_J;
        else         sr[g] <= {dp_i, dm_i};
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr[g] <= LS_J;
        else         sr[g] <= sr[g-1];
      end
    end
  end

  assign state_o = line_state_e'(sr[STAGES-1]);

endmodule

// File: rtl/usb_bus_state_det.sv
module usb_bus_state_det
  import usb_irq_pkg::*;
#(
  parameter int unsigned SE0_CYCLES  = 120,
  parameter int unsigned IDLE_CYCLES = 144000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  line_state_e ls_i,
  output bus_evt_t    evt_o,
  output logic        susp_o
);

  localparam int unsigned SW = $clog2(SE0_CYCLES + 1);
  localparam int unsigned IW = $clog2(IDLE_CYCLES + 1);
  localparam logic [SW-1:0] SE0_LAST  = SW'(SE0_CYCLES - 1);
  localparam logic [SW-1:0] SE0_SAT   = SW'(SE0_CYCLES);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYCLES - 1);
  localparam logic [IW-1:0] IDLE_SAT  = IW'(IDLE_CYCLES);

  line_state_e   prev_ls;
  logic [SW-1:0] se0_cnt;
  logic [IW-1:0] idle_cnt;
  logic          susp_q;
  logic          is_se0, is_j, is_k;

  assign is_se0 = (ls_i == LS_SE0);
  assign is_j   = (ls_i == LS_J);
  assign is_k   = (ls_i == LS_K);

  // single-cycle event pulses
  always_comb begin
    evt_o.bus_rst = is_se0 && (se0_cnt == SE0_LAST);
    evt_o.susp    = is_j && !susp_q && (idle_cnt == IDLE_LAST);
    evt_o.rsm     = susp_q && (prev_ls == LS_J) && is_k;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_ls <= LS_J;
    end else begin
      prev_ls <= ls_i;
    end
  end

  // consecutive SE0 samples, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      se0_cnt <= '0;
    end else if (!is_se0) begin
      se0_cnt <= '0;
    end else if (se0_cnt != SE0_SAT) begin
      se0_cnt <= se0_cnt + 1'b1;
    end
  end

  // consecutive idle (J) samples while awake, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_cnt <= '0;
    end else if (!is_j || susp_q) begin
      idle_cnt <= '0;
    end else if (idle_cnt != IDLE_SAT) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      susp_q <= 1'b0;
    end else if (evt_o.bus_rst || evt_o.rsm) begin
      susp_q <= 1'b0;
    end else if (evt_o.susp) begin
      susp_q <= 1'b1;
    end
  end

  assign susp_o = susp_q;

endmodule

// File: rtl/usb_irq_regs.sv
module usb_irq_regs
  import usb_irq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  bus_evt_t    evt_i,
  input  logic        susp_live_i,
  input  logic        ph_irq_i,
  input  logic        tx_done_i,
  input  logic        rx_done_i,
  input  logic        reg_wr_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        irq_o,
  output flag_t       flags_o,
  output logic [15:0] enable_o
);

  logic [15:0] enable_q;
  flag_t       flags_q, set_v, clr_v;
  logic        wr_stat, wr_rsts;

  assign wr_stat = reg_wr_i && (reg_addr_i == ADDR_STATUS);
  assign wr_rsts = reg_wr_i && (reg_addr_i == ADDR_RSTSTS);

  always_comb begin
    set_v.tx      = tx_done_i;
    set_v.rx      = rx_done_i;
    set_v.bus_rst = evt_i.bus_rst;
    set_v.susp    = evt_i.susp;
    set_v.rsm     = evt_i.rsm;
    clr_v.tx      = wr_stat && reg_wdata_i[B_TXDMA];
    clr_v.rx      = wr_stat && reg_wdata_i[B_RXDMA];
    clr_v.susp    = wr_stat && reg_wdata_i[B_SUSP];
    clr_v.rsm     = wr_stat && reg_wdata_i[B_RSM];
    clr_v.bus_rst = wr_rsts && reg_wdata_i[B_RSTFLAG];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= '0;
      flags_q  <= '0;
    end else begin
      if (reg_wr_i && (reg_addr_i == ADDR_ENABLE)) begin
        enable_q <= reg_wdata_i & ENABLE_IMPL;
      end
      // a new event overrides a clear in the same cycle
      flags_q <= (flags_q & ~clr_v) | set_v;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_ENABLE: reg_rdata_o = enable_q;
      ADDR_STATUS: begin
        reg_rdata_o[B_TXDMA]     = flags_q.tx;
        reg_rdata_o[B_RXDMA]     = flags_q.rx;
        reg_rdata_o[B_LIVE_SUSP] = susp_live_i;
        reg_rdata_o[B_PHLINE]    = ph_irq_i;
        reg_rdata_o[B_SUSP]      = flags_q.susp;
        reg_rdata_o[B_RSM]       = flags_q.rsm;
      end
      ADDR_RSTSTS: reg_rdata_o[B_RSTFLAG] = flags_q.bus_rst;
      default:     reg_rdata_o = '0;
    endcase
  end

  assign irq_o = (flags_q.tx      && enable_q[B_TXDMA])
              || (flags_q.rx      && enable_q[B_RXDMA])
              || (flags_q.bus_rst && enable_q[B_BUSRST_EN])
              || (ph_irq_i        && enable_q[B_PHLINE])
              || (flags_q.susp    && enable_q[B_SUSP])
              || (flags_q.rsm     && enable_q[B_RSM]);

  assign flags_o  = flags_q;
  assign enable_o = enable_q;

endmodule

// File: rtl/usb_bus_irq_ctrl.sv
module usb_bus_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SE0_CYCLES  = 120,
  parameter int unsigned IDLE_CYCLES = 144000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        usb_dp_i,
  input  logic        usb_dm_i,
  input  logic        ph_irq_i,
  input  logic        tx_dma_done_i,
  input  logic        rx_dma_done_i,
  input  logic        reg_wr_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        irq_o
);

  line_state_e line_ls;
  bus_evt_t    bus_evt;
  logic        susp_live;
  flag_t       flags;
  logic [15:0] enable_q;

  usb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dp_i    (usb_dp_i),
    .dm_i    (usb_dm_i),
    .state_o (line_ls)
  );

  usb_bus_state_det #(
    .SE0_CYCLES  (SE0_CYCLES),
    .IDLE_CYCLES (IDLE_CYCLES)
  ) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ls_i   (line_ls),
    .evt_o  (bus_evt),
    .susp_o (susp_live)
  );

  usb_irq_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (bus_evt),
    .susp_live_i (susp_live),
    .ph_irq_i    (ph_irq_i),
    .tx_done_i   (tx_dma_done_i),
    .rx_done_i   (rx_dma_done_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .flags_o     (flags),
    .enable_o    (enable_q)
  );

endmodule

// File: rtl/usb_bus_irq_ctrl_chk.sv
module usb_bus_irq_ctrl_chk
  import usb_irq_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input bus_evt_t    evt,
  input logic        susp_live,
  input flag_t       flags,
  input logic [15:0] enable_q,
  input logic        irq_o,
  input logic        tx_dma_done_i,
  input logic        rx_dma_done_i,
  input logic        reg_wr_i,
  input logic [1:0]  reg_addr_i,
  input logic [15:0] reg_wdata_i
);

  AST_RST_EVT_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt.bus_rst |=> flags.bus_rst && !susp_live); // R2

  AST_SUSP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt.susp |=> susp_live && flags.susp); // R3

  AST_RESUME_WAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt.rsm |=> !susp_live && flags.rsm); // R4

  AST_WAKE_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(susp_live) |-> $past(evt.rsm || evt.bus_rst)); // R5

  AST_DMA_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_dma_done_i || rx_dma_done_i) |=>
      ((flags.tx || !$past(tx_dma_done_i)) && (flags.rx || !$past(rx_dma_done_i)))); // R6

  AST_NO_IRQ_ALL_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_q == 16'h0000) |-> !irq_o); // R8

  AST_W1C_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_STATUS && reg_wdata_i[B_TXDMA] && !tx_dma_done_i)
      |=> !flags.tx); // R9

endmodule

bind usb_bus_irq_ctrl usb_bus_irq_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .evt           (bus_evt),
  .susp_live     (susp_live),
  .flags         (flags),
  .enable_q      (enable_q),
  .irq_o         (irq_o),
  .tx_dma_done_i (tx_dma_done_i),
  .rx_dma_done_i (rx_dma_done_i),
  .reg_wr_i      (reg_wr_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i)
);

// File: tb/usb_bus_irq_ctrl_tb_top.sv
module usb_bus_irq_ctrl_tb_top;
  import usb_irq_pkg::*;

  localparam int unsigned SE0_N  = 8;
  localparam int unsigned IDLE_N = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dp = 1'b1, dm = 1'b0;
  logic        ph_irq = 1'b0, tx_done = 1'b0, rx_done = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usb_bus_irq_ctrl #(
    .SYNC_STAGES (2),
    .SE0_CYCLES  (SE0_N),
    .IDLE_CYCLES (IDLE_N)
  ) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .usb_dp_i      (dp),
    .usb_dm_i      (dm),
    .ph_irq_i      (ph_irq),
    .tx_dma_done_i (tx_done),
    .rx_dma_done_i (rx_done),
    .reg_wr_i      (wr),
    .reg_addr_i    (addr),
    .reg_wdata_i   (wdata),
    .reg_rdata_o   (rdata),
    .irq_o         (irq)
  );

  // {line[1:0], hold[7:0], status[15:0], reset flag}
  localparam int NSTEP = 9;
  localparam logic [26:0] STEPS [NSTEP] = '{
    {2'b01, 8'd10, 16'h0000, 1'b0},  // activity, awake
    {2'b10, 8'd20, 16'h0000, 1'b0},  // short idle
    {2'b01, 8'd5,  16'h0000, 1'b0},  // activity restarts idle count
    {2'b10, 8'd60, 16'h0102, 1'b0},  // long idle: suspend
    {2'b10, 8'd10, 16'h0102, 1'b0},  // stays suspended
    {2'b01, 8'd5,  16'h0003, 1'b0},  // J->K: resume
    {2'b00, 8'd12, 16'h0003, 1'b1},  // long SE0: bus reset
    {2'b10, 8'd60, 16'h0103, 1'b1},  // suspend again
    {2'b00, 8'd12, 16'h0003, 1'b1}   // reset ends suspend, no resume flag
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_line(input logic [1:0] ls);
    {dp, dm} = ls;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    logic [15:0] v;
    set_line(LS_J);
    cycles(4);
    rst_n = 1'b1;
    cycles(1);

    // R1: reset state
    reg_read(ADDR_ENABLE, v); check("R1 enable", v, 16'h0000);
    reg_read(ADDR_STATUS, v); check("R1 status", v, 16'h0000);
    reg_read(ADDR_RSTSTS, v); check("R1 rststs", v, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);

    // table walk: R2 R3 R4 R5 over line sequences
    for (int i = 0; i < NSTEP; i++) begin
      set_line(STEPS[i][26:25]);
      cycles(int'(STEPS[i][24:17]) + 3);
      reg_read(ADDR_STATUS, v);
      check($sformatf("R3/R4/R5 step %0d status", i), v, STEPS[i][16:1]);
      reg_read(ADDR_RSTSTS, v);
      check($sformatf("R2 step %0d rststs", i), v, {11'd0, STEPS[i][0], 4'd0});
    end

    // R9: write-one-to-clear, live bits untouched
    set_line(LS_K);
    cycles(3);
    reg_write(ADDR_STATUS, 16'hFFFF);
    reg_read(ADDR_STATUS, v); check("R9 status cleared", v, 16'h0000);
    reg_write(ADDR_RSTSTS, 16'hFFFF);
    reg_read(ADDR_RSTSTS, v); check("R9 rststs cleared", v, 16'h0000);

    // R7: reserved enable bits read zero
    reg_write(ADDR_ENABLE, 16'hFFFF);
    reg_read(ADDR_ENABLE, v); check("R7 enable impl bits", v, 16'h0743);
    reg_read(2'd3, v); check("R7 addr3", v, 16'h0000);
    check("R8 no flags no irq", {15'd0, irq}, 16'h0000);

    // R6/R8: tx DMA
    tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    reg_read(ADDR_STATUS, v); check("R6 tx flag", v, 16'h0400);
    check("R8 tx irq", {15'd0, irq}, 16'h0001);
    reg_write(ADDR_ENABLE, 16'h0000);
    check("R8 masked irq low", {15'd0, irq}, 16'h0000);
    reg_read(ADDR_STATUS, v); check("R8 masked flag kept", v, 16'h0400);

    // R9: set wins over same-cycle clear
    tx_done = 1'b1;
    reg_write(ADDR_STATUS, 16'h0400);
    tx_done = 1'b0;
    reg_read(ADDR_STATUS, v); check("R9 set beats clear", v, 16'h0400);
    reg_write(ADDR_STATUS, 16'h0400);
    reg_read(ADDR_STATUS, v); check("R9 tx cleared", v, 16'h0000);

    // R6: rx DMA and protocol-handler line
    rx_done = 1'b1; @(negedge clk); rx_done = 1'b0;
    reg_read(ADDR_STATUS, v); check("R6 rx flag", v, 16'h0200);
    ph_irq = 1'b1;
    reg_read(ADDR_STATUS, v); check("R6 ph line high", v, 16'h0240);
    reg_write(ADDR_ENABLE, 16'h0040);
    check("R8 ph irq", {15'd0, irq}, 16'h0001);
    reg_write(ADDR_STATUS, 16'h0040);
    reg_read(ADDR_STATUS, v); check("R9 ph bit not clearable", v, 16'h0240);
    ph_irq = 1'b0;
    reg_read(ADDR_STATUS, v); check("R6 ph line low", v, 16'h0200);
    check("R8 ph irq gone", {15'd0, irq}, 16'h0000);

    // R8: reset flag pairs with enable bit 8
    reg_write(ADDR_STATUS, 16'h0200);
    reg_write(ADDR_ENABLE, 16'h0100);

    // R2 threshold: one sample short
    set_line(LS_SE0); cycles(SE0_N - 1);
    set_line(LS_K); cycles(5);
    reg_read(ADDR_RSTSTS, v); check("R2 short SE0", v, 16'h0000);
    check("R8 no reset irq", {15'd0, irq}, 16'h0000);
    // R2 threshold: exactly at limit
    set_line(LS_SE0); cycles(SE0_N);
    set_line(LS_K); cycles(5);
    reg_read(ADDR_RSTSTS, v); check("R2 exact SE0", v, 16'h0010);
    check("R8 reset irq", {15'd0, irq}, 16'h0001);
    reg_write(ADDR_RSTSTS, 16'h0010);
    reg_write(ADDR_ENABLE, 16'h0000);

    // R3 threshold: one sample short, then SE1 breaks an idle run
    set_line(LS_J); cycles(IDLE_N - 1);
    set_line(LS_K); cycles(5);
    reg_read(ADDR_STATUS, v); check("R3 short idle", v, 16'h0000);
    set_line(LS_J); cycles(30);
    set_line(LS_SE1); cycles(2);
    set_line(LS_J); cycles(30);
    set_line(LS_K); cycles(5);
    reg_read(ADDR_STATUS, v); check("R3 SE1 restarts idle", v, 16'h0000);
    // R3 exact limit, then K straight after gives R4 resume
    set_line(LS_J); cycles(IDLE_N);
    set_line(LS_K); cycles(5);
    reg_read(ADDR_STATUS, v); check("R3/R4 exact idle then resume", v, 16'h0003);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule